// File: doc/BRIEF.md
# Page-Mode Asynchronous Memory Read Sequencer

This block turns host read requests into read cycles on an external asynchronous memory. The memory has a 24-bit byte address and an 8-bit data bus. The host offers an address with a valid/ready handshake. The block then holds chip select and read strobe low (both active low) for a programmed number of clock cycles. It samples the data bus on the last cycle of that pulse and hands the byte back with a single-cycle valid.

With page mode on, the block remembers which aligned page it last opened. The page size is 4, 8, 16 or 32 bytes. A request that arrives on the response cycle of the previous access, and falls in the same page, gets the short in-page pulse. Any other access gets the long first-access pulse. During such a burst the strobes stay low from the first access to the last. They are released only when no request follows. With page mode off, every read is a standalone access and the strobes go high between reads.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, mem_ncs and mem_nrd are high, rsp_valid is low and req_ready is high.
- R2: A request accepted while idle drives mem_addr with the request address and pulls mem_ncs and mem_nrd low for exactly max(1, cfg_first_len) clock cycles.
- R3: The byte on mem_data during the last pulse cycle is returned on rsp_data. rsp_valid is high for exactly one cycle, the cycle after the pulse.
- R4: With cfg_page_en high, a request accepted on a response cycle whose page address equals that of the previous access uses a pulse of max(1, cfg_next_len) cycles. The page address is req_addr[23:2+cfg_page_sel], with cfg_page_sel 0, 1, 2, 3 meaning 4, 8, 16, 32-byte pages.
- R5: In a burst, a request to a different page uses the first-access pulse length, and later hits compare against the new page.
- R6: With cfg_page_en high, mem_ncs and mem_nrd stay low on the response cycle between accesses of a burst.
- R7: mem_ncs and mem_nrd are always equal.
- R8: If no request is accepted on a response cycle, the strobes go high on the next cycle and the page is closed. The next access then uses the first-access length.
- R9: With cfg_page_en low, every access uses the first-access length, and the strobes are high on the response cycle.
- R10: A change of cfg_page_sel while a page is open closes it, so the next access uses the first-access length.
- R11: A programmed length of zero gives a one-cycle pulse.
- R12: req_ready is high only while idle or on a page-mode response cycle, never during a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_page_en | input | 1 | Page-mode enable |
| cfg_page_sel | input | 2 | Page size code: 0=4, 1=8, 2=16, 3=32 bytes |
| cfg_first_len | input | 8 | First-access pulse length in cycles |
| cfg_next_len | input | 8 | In-page pulse length in cycles |
| req_valid | input | 1 | Host request valid |
| req_addr | input | 24 | Host byte address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| mem_addr | output | 24 | Memory address bus |
| mem_ncs | output | 1 | Chip select, active low |
| mem_nrd | output | 1 | Read strobe, active low |
| mem_data | input | 8 | Memory data bus |

## Verification
The hardest case to reach is the in-page hit. It exists only when the next request is already waiting on the single response cycle of the previous access. The bench therefore raises the following request as soon as the current one is taken, and holds it through the whole pulse. This lets back-to-back bursts run across page boundaries for every page size and timing pair. Closing a page through a size change needs a configuration edit inside a pulse. The bench makes this edit on the cycle right after a request is accepted.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } pgrd_st_e;

    localparam int PAGE_SEL_W = 2;
    localparam int PAGE_MIN_LG = 2;
endpackage

// File: rtl/pgrd_page_cmp.sv
module pgrd_page_cmp #(
    parameter int ADDR_W   = 24,
    parameter int SEL_W    = 2,
    parameter int BASE_OFS = 2
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);
    localparam int TOP_OFS = BASE_OFS + (1 << SEL_W) - 1;

    logic [ADDR_W-1:0] care;

    // bit i belongs to the page address when i >= BASE_OFS + sel
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        if (i < BASE_OFS) begin : g_low
            assign care[i] = 1'b0;
        end else if (i >= TOP_OFS) begin : g_high
            assign care[i] = 1'b1;
        end else begin : g_mid
            assign care[i] = ($unsigned(i - BASE_OFS) >= 32'(sel));
        end
    end

    assign hit = ~|((addr_a ^ addr_b) & care);
endmodule

// File: rtl/pgrd_len_load.sv
module pgrd_len_load #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] first_len,
    input  logic [LEN_W-1:0] next_len,
    input  logic             use_next,
    output logic [LEN_W-1:0] load
);
    logic [LEN_W-1:0] pick;

    always_comb begin
        pick = use_next ? next_len : first_len;
        load = (pick == '0) ? '0 : pick - LEN_W'(1);
    end
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_page_en,
    input  logic [pgrd_pkg::PAGE_SEL_W-1:0] cfg_page_sel,
    input  logic [LEN_W-1:0]              cfg_first_len,
    input  logic [LEN_W-1:0]              cfg_next_len,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          req_ready,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mem_ncs,
    output logic                          mem_nrd,
    input  logic [DATA_W-1:0]             mem_data
);
    import pgrd_pkg::*;

    typedef struct packed {
        pgrd_st_e                st;
        logic [LEN_W-1:0]        cnt;
        logic [ADDR_W-1:0]       addr;
        logic                    page_vld;
        logic [PAGE_SEL_W-1:0]   sel_snap;
        logic                    rsp_vld;
        logic [DATA_W-1:0]       rsp_data;
    } regs_t;

    regs_t r_q, r_d;

    logic             accept;
    logic             same_page;
    logic             page_open;
    logic             use_next;
    logic [LEN_W-1:0] len_load;

    pgrd_page_cmp #(
        .ADDR_W   (ADDR_W),
        .SEL_W    (PAGE_SEL_W),
        .BASE_OFS (PAGE_MIN_LG)
    ) page_cmp_i (
        .addr_a (req_addr),
        .addr_b (r_q.addr),
        .sel    (cfg_page_sel),
        .hit    (same_page)
    );

    pgrd_len_load #(
        .LEN_W (LEN_W)
    ) len_load_i (
        .first_len (cfg_first_len),
        .next_len  (cfg_next_len),
        .use_next  (use_next),
        .load      (len_load)
    );

    always_comb begin
        req_ready = (r_q.st == ST_IDLE) || ((r_q.st == ST_GAP) && cfg_page_en);
        accept    = req_valid && req_ready;
        page_open = r_q.page_vld && cfg_page_en && (r_q.sel_snap == cfg_page_sel);
        use_next  = (r_q.st == ST_GAP) && page_open && same_page;
    end

    always_comb begin
        r_d         = r_q;
        r_d.rsp_vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.page_vld = 1'b0;
                if (accept) begin
                    r_d.st       = ST_PULSE;
                    r_d.addr     = req_addr;
                    r_d.cnt      = len_load;
                    r_d.page_vld = cfg_page_en;
                    r_d.sel_snap = cfg_page_sel;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.rsp_vld  = 1'b1;
                    r_d.rsp_data = mem_data;
                    r_d.st       = cfg_page_en ? ST_GAP : ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - LEN_W'(1);
                end
            end
            ST_GAP: begin
                if (accept) begin
                    r_d.st       = ST_PULSE;
                    r_d.addr     = req_addr;
                    r_d.cnt      = len_load;
                    r_d.page_vld = 1'b1;
                    r_d.sel_snap = cfg_page_sel;
                end else begin
                    r_d.st       = ST_IDLE;
                    r_d.page_vld = 1'b0;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, addr: '0, page_vld: 1'b0,
                     sel_snap: '0, rsp_vld: 1'b0, rsp_data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_ncs   = (r_q.st == ST_IDLE);
    assign mem_nrd   = (r_q.st == ST_IDLE);
    assign rsp_valid = r_q.rsp_vld;
    assign rsp_data  = r_q.rsp_data;
endmodule

// File: rtl/pgrd_ctrl_chk.sv
module pgrd_ctrl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ncs,
    input logic              mem_nrd
);
    AST_STROBES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ncs == mem_nrd); // R7

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

    AST_NO_READY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_nrd || rsp_valid)); // R12

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ncs && $past(!mem_ncs) && !$past(rsp_valid)) |-> $stable(mem_addr)); // R2

    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(!mem_nrd)); // R11
endmodule

bind pgrd_ctrl pgrd_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ncs   (mem_ncs),
    .mem_nrd   (mem_nrd)
);

// File: tb/pgrd_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgrd_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pe = 1'b0;
    logic [1:0]  cfg_ps = 2'd0;
    logic [7:0]  cfg_fl = 8'd4;
    logic [7:0]  cfg_nl = 8'd2;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ncs, mem_nrd;
    logic [7:0]  rsp_data, mem_data;
    logic [23:0] mem_addr;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    logic [23:0] seq [8];

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
    endfunction

    assign mem_data = mem_nrd ? 8'h00 : mem_fn(mem_addr);

    pgrd_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_page_en (cfg_pe), .cfg_page_sel (cfg_ps),
        .cfg_first_len (cfg_fl), .cfg_next_len (cfg_nl),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .mem_addr (mem_addr), .mem_ncs (mem_ncs), .mem_nrd (mem_nrd),
        .mem_data (mem_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_burst(input int n, input int chg_idx, input logic [1:0] new_ps);
        bit hit;
        int len;
        int c;
        for (int i = 0; i < n; i++) begin
            req_addr  = seq[i];
            req_valid = 1'b1;
            while (!req_ready) @(negedge clk);
            hit = cfg_pe && (i > 0) && (i != chg_idx) &&
                  ((seq[i] >> (2 + cfg_ps)) == (seq[i-1] >> (2 + cfg_ps)));
            if (!cfg_pe && i > 0) chk(mem_ncs && mem_nrd, "R9", {mem_ncs, mem_nrd}, 2'b11);
            @(negedge clk);
            if (i == n - 1) req_valid = 1'b0;
            if (i + 1 == chg_idx) cfg_ps = new_ps;
            chk(!req_ready, "R12", req_ready, 0);
            chk(mem_addr == seq[i] && !mem_nrd, "R2", mem_addr, seq[i]);
            chk(mem_ncs == mem_nrd, "R7", mem_ncs, mem_nrd);
            len = hit ? int'(cfg_nl) : int'(cfg_fl);
            if (len == 0) len = 1;
            c = 1;
            while (!rsp_valid && c < 600) begin
                @(negedge clk);
                c++;
            end
            if (hit) chk(c == len + 1, "R4", c, len + 1);
            else if (cfg_fl == 0) chk(c == len + 1, "R11", c, len + 1);
            else if (i == chg_idx) chk(c == len + 1, "R10", c, len + 1);
            else if (!cfg_pe) chk(c == len + 1, "R9", c, len + 1);
            else chk(c == len + 1, "R5", c, len + 1);
            chk(rsp_data == mem_fn(seq[i]), "R3", rsp_data, mem_fn(seq[i]));
            if (cfg_pe) chk(!mem_ncs && !mem_nrd, "R6", {mem_ncs, mem_nrd}, 2'b00);
        end
        @(negedge clk);
        chk(mem_ncs && mem_nrd, "R8", {mem_ncs, mem_nrd}, 2'b11);
        chk(!rsp_valid, "R3", rsp_valid, 0);
    endtask

    task automatic load_seq(input int which);
        if (which == 0) begin
            for (int k = 0; k < 8; k++) seq[k] = 24'h12343C + 24'(k);
        end else begin
            seq[0] = 24'hABCDE0; seq[1] = 24'hABCDFF; seq[2] = 24'hABCDE4; seq[3] = 24'h000000;
            seq[4] = 24'h00001F; seq[5] = 24'h00001C; seq[6] = 24'hFFFFFF; seq[7] = 24'hFFFFE0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ncs && mem_nrd && !rsp_valid && req_ready, "R1",
            {mem_ncs, mem_nrd, rsp_valid, req_ready}, 4'b1101);
        for (int pe = 0; pe < 2; pe++) begin
            for (int ps = 0; ps < 4; ps++) begin
                for (int lp = 0; lp < 4; lp++) begin
                    for (int sq = 0; sq < 2; sq++) begin
                        cfg_pe = pe[0];
                        cfg_ps = 2'(ps);
                        case (lp)
                            0: begin cfg_fl = 8'd6; cfg_nl = 8'd2; end
                            1: begin cfg_fl = 8'd3; cfg_nl = 8'd1; end
                            2: begin cfg_fl = 8'd0; cfg_nl = 8'd0; end
                            default: begin cfg_fl = 8'd4; cfg_nl = 8'd0; end
                        endcase
                        load_seq(sq);
                        run_burst(8, 99, 2'd0);
                        // second burst on the same page: page closed after idle
                        run_burst(2, 99, 2'd0);
                    end
                end
            end
        end
        // page size change inside a burst closes the page
        cfg_pe = 1'b1; cfg_fl = 8'd5; cfg_nl = 8'd2;
        for (int ps = 0; ps < 4; ps++) begin
            cfg_ps = 2'(ps);
            load_seq(0);
            run_burst(8, 3, 2'(3 - ps));
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule